// File: doc/BRIEF.md
# Interrupt crossbar routing fabric

This block steers peripheral interrupt sources onto the output lines that feed the shared-peripheral range of a downstream interrupt controller. Output line i reaches controller index 32 + i. The block has N_SRC level-sensitive source inputs and N_OUT output lines. Each output line takes one of three forms, fixed when the block is elaborated:

- **Programmable:** the line has a select register that holds the number of the source routed to it.
- **Bypass:** the line is wired to a fixed source. It keeps a register slot, which reads back that fixed source number, and writes to the slot are discarded.
- **Reserved:** the line has no register, uses no address space and is held low.

Software reaches the select registers through a plain byte-addressed bus. Each register is REG_BYTES wide and has a byte enable per byte. Registers sit back to back in ascending line order, and reserved lines are left out of the sequence. A synchronous active-low reset loads the safe source number into every programmable line. Routing from sources to outputs is purely combinational, so an interrupt level passes through with no added latency.

Top module: `irq_xbar`

## Requirements
- R1: The register of non-reserved line i sits at byte offset REG_BYTES times the number of non-reserved lines below i. Reserved lines have no offset. Any other address, including one not a multiple of REG_BYTES, is unmapped.
- R2: Each select register is 8*REG_BYTES bits wide. REG_BYTES must be 1, 2 or 4, and any other value stops elaboration with an error.
- R3: While rst_n is low at a rising clock edge, every programmable line is loaded with SAFE_SEL.
- R4: A programmable line whose select value s is below N_SRC drives out_irq[i] = in_irq[s]. A write takes effect at the clock edge where wr is high, and not before that edge.
- R5: A programmable line whose select value is N_SRC or above drives its output low.
- R6: Reserved lines drive out_irq low at all times.
- R7: A bypass line always drives in_irq[BYPASS_SRC[i]]. Writes to its slot change neither its routing nor its readback, and a read of its slot returns BYPASS_SRC[i].
- R8: A write updates byte b of the addressed register (bits 8b+7..8b) only where be[b] is 1. The other bytes keep their value.
- R9: rdata is combinational. With rd high and a mapped address, it shows the addressed register. With rd low, or with an unmapped address, it is zero, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_irq | input | N_SRC | Level interrupt sources |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 8*REG_BYTES | Write data |
| be | input | REG_BYTES | Byte enables for writes |
| wr | input | 1 | Write strobe, sampled at the rising edge |
| rd | input | 1 | Read strobe, combinational read |
| rdata | output | 8*REG_BYTES | Read data, zero when idle or unmapped |
| out_irq | output | N_OUT | Routed lines to the downstream controller |

## Verification
The bench builds the block with the following parameter values:

- **Sources:** twelve, so that the four-bit select index can reach the out-of-range codes 12 to 15 without a wider register.
- **Register size:** two-byte registers, which give partial byte enables a real effect and make odd addresses misaligned holes.
- **Reserved lines:** lines 2 and 5, which shift the offsets of every line above them.
- **Bypass lines:** lines 3 and 7, wired to sources 11 and 4.
- **Safe source:** 9, which lies inside the source range, so the state after reset is visible on the outputs.

With these values the bench reaches the exact-boundary select value N_SRC, the largest valid select, and a write whose high byte alone pushes the select out of range.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

   // Number of non-reserved lines with an index below idx (slot number of line idx).
   function automatic int slots_below(logic [63:0] res_mask, int idx);
      int n;
      n = 0;
      for (int j = 0; j < 64; j++) begin
         if (j < idx && !res_mask[j]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec #(
   parameter int          N_OUT         = 8,
   parameter int          REG_BYTES     = 1,
   parameter int          ADDR_W        = 8,
   parameter logic [N_OUT-1:0] RESERVED_MASK = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_OUT-1:0]  hit
);
   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      if (RESERVED_MASK[i]) begin : g_none
         assign hit[i] = 1'b0;
      end else begin : g_slot
         localparam int OFFSET = REG_BYTES * xbar_pkg::slots_below(64'(RESERVED_MASK), i);
         assign hit[i] = (addr == ADDR_W'(OFFSET));
      end
   end
endmodule

// File: rtl/xbar_sel_reg.sv
module xbar_sel_reg #(
   parameter int          REG_BYTES = 1,
   parameter int unsigned SAFE_SEL  = 0,
   localparam int         SEL_W     = 8 * REG_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_BYTES-1:0] be,
   input  logic [SEL_W-1:0]     wdata,
   output logic [SEL_W-1:0]     sel_q
);
   localparam logic [SEL_W-1:0] RST_VAL = SEL_W'(SAFE_SEL);

   for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (!rst_n)
            sel_q[b*8 +: 8] <= RST_VAL[b*8 +: 8];
         else if (wr_en && be[b])
            sel_q[b*8 +: 8] <= wdata[b*8 +: 8];
      end
   end
endmodule

// File: rtl/xbar_route.sv
module xbar_route #(
   parameter int N_SRC = 16,
   parameter int SEL_W = 8
) (
   input  logic [N_SRC-1:0] in_irq,
   input  logic [SEL_W-1:0] sel,
   output logic             irq
);
   localparam int             IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(N_SRC);

   logic in_range;
   assign in_range = ({1'b0, sel} < LIMIT);
   assign irq      = in_range ? in_irq[sel[IDX_W-1:0]] : 1'b0;
endmodule

// File: rtl/irq_xbar.sv
module irq_xbar #(
   parameter int                    N_SRC         = 16,
   parameter int                    N_OUT         = 8,
   parameter int                    REG_BYTES     = 1,
   parameter int                    ADDR_W        = 8,
   parameter int unsigned           SAFE_SEL      = 0,
   parameter logic [N_OUT-1:0]      RESERVED_MASK = '0,
   parameter logic [N_OUT-1:0]      BYPASS_MASK   = '0,
   parameter logic [N_OUT-1:0][7:0] BYPASS_SRC    = '0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       in_irq,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [8*REG_BYTES-1:0] wdata,
   input  logic [REG_BYTES-1:0]   be,
   input  logic                   wr,
   input  logic                   rd,
   output logic [8*REG_BYTES-1:0] rdata,
   output logic [N_OUT-1:0]       out_irq
);
   localparam int SEL_W   = 8 * REG_BYTES;
   localparam int N_SLOTS = xbar_pkg::slots_below(64'(RESERVED_MASK), N_OUT);
   localparam int SPAN    = N_SLOTS * REG_BYTES;

   // R2: elaboration-time parameter checks
   if (!(REG_BYTES == 1 || REG_BYTES == 2 || REG_BYTES == 4)) begin : g_bad_size
      $error("irq_xbar: REG_BYTES must be 1, 2 or 4");
   end
   if (N_OUT < 1 || N_OUT > 64) begin : g_bad_nout
      $error("irq_xbar: N_OUT must lie in 1..64");
   end
   if (N_SRC < 1 || (SEL_W < 31 && N_SRC > (1 << SEL_W))) begin : g_bad_nsrc
      $error("irq_xbar: N_SRC does not fit the select register");
   end
   if (SEL_W < 32 && SAFE_SEL >= (32'd1 << SEL_W)) begin : g_bad_safe
      $error("irq_xbar: SAFE_SEL does not fit the select register");
   end
   if ((RESERVED_MASK & BYPASS_MASK) != '0) begin : g_bad_overlap
      $error("irq_xbar: a line cannot be both reserved and bypass");
   end
   if (ADDR_W < 31 && SPAN > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_xbar: ADDR_W too narrow for the register span");
   end

   logic [N_OUT-1:0] hit;
   logic [SEL_W-1:0] rd_val [N_OUT];

   xbar_addr_dec #(
      .N_OUT        (N_OUT),
      .REG_BYTES    (REG_BYTES),
      .ADDR_W       (ADDR_W),
      .RESERVED_MASK(RESERVED_MASK)
   ) u_dec (
      .addr(addr),
      .hit (hit)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_line
      if (RESERVED_MASK[i]) begin : g_reserved
         assign out_irq[i] = 1'b0;
         assign rd_val[i]  = '0;
      end else if (BYPASS_MASK[i]) begin : g_bypass
         if (int'(BYPASS_SRC[i]) >= N_SRC) begin : g_bad_byp
            $error("irq_xbar: bypass source out of range");
         end
         assign out_irq[i] = in_irq[BYPASS_SRC[i]];
         assign rd_val[i]  = SEL_W'(BYPASS_SRC[i]);
      end else begin : g_prog
         logic [SEL_W-1:0] sel_q;

         xbar_sel_reg #(
            .REG_BYTES(REG_BYTES),
            .SAFE_SEL (SAFE_SEL)
         ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(wr & hit[i]),
            .be   (be),
            .wdata(wdata),
            .sel_q(sel_q)
         );

         xbar_route #(
            .N_SRC(N_SRC),
            .SEL_W(SEL_W)
         ) u_route (
            .in_irq(in_irq),
            .sel   (sel_q),
            .irq   (out_irq[i])
         );

         assign rd_val[i] = sel_q;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         for (int i = 0; i < N_OUT; i++) begin
            if (hit[i]) rdata = rdata | rd_val[i];
         end
      end
   end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
   parameter int                    N_SRC         = 16,
   parameter int                    N_OUT         = 8,
   parameter int                    REG_BYTES     = 1,
   parameter int                    ADDR_W        = 8,
   parameter int unsigned           SAFE_SEL      = 0,
   parameter logic [N_OUT-1:0]      RESERVED_MASK = '0,
   parameter logic [N_OUT-1:0]      BYPASS_MASK   = '0,
   parameter logic [N_OUT-1:0][7:0] BYPASS_SRC    = '0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_SRC-1:0]       in_irq,
   input logic [ADDR_W-1:0]      addr,
   input logic                   rd,
   input logic [8*REG_BYTES-1:0] rdata,
   input logic [N_OUT-1:0]       out_irq
);
   localparam int N_SLOTS = xbar_pkg::slots_below(64'(RESERVED_MASK), N_OUT);
   localparam logic [N_OUT-1:0] PROG_MASK = ~(RESERVED_MASK | BYPASS_MASK);

   logic [N_OUT-1:0]       byp_exp;
   logic [N_OUT-1:0]       safe_exp;
   logic                   mapped;
   logic                   byp_hit;
   logic [8*REG_BYTES-1:0] byp_val;

   always_comb begin
      byp_exp = '0;
      byp_hit = 1'b0;
      byp_val = '0;
      for (int i = 0; i < N_OUT; i++) begin
         if (BYPASS_MASK[i]) begin
            byp_exp[i] = in_irq[BYPASS_SRC[i]];
            if (int'(addr) == REG_BYTES * xbar_pkg::slots_below(64'(RESERVED_MASK), i)) begin
               byp_hit = 1'b1;
               byp_val = (8*REG_BYTES)'(BYPASS_SRC[i]);
            end
         end
      end
      safe_exp = (SAFE_SEL < N_SRC) ? {N_OUT{in_irq[SAFE_SEL]}} : '0;
      mapped   = (int'(addr) < N_SLOTS * REG_BYTES) && ((int'(addr) % REG_BYTES) == 0);
   end

   // R6
   reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_irq & RESERVED_MASK) == '0);

   // R7
   bypass_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_irq & BYPASS_MASK) == (byp_exp & BYPASS_MASK));

   // R7
   bypass_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && byp_hit) |-> (rdata == byp_val));

   // R9
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));

   // R9
   unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !mapped) |-> (rdata == '0));

   // R3
   reset_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((out_irq & PROG_MASK) == (safe_exp & PROG_MASK)));
endmodule

bind irq_xbar xbar_chk #(
   .N_SRC        (N_SRC),
   .N_OUT        (N_OUT),
   .REG_BYTES    (REG_BYTES),
   .ADDR_W       (ADDR_W),
   .SAFE_SEL     (SAFE_SEL),
   .RESERVED_MASK(RESERVED_MASK),
   .BYPASS_MASK  (BYPASS_MASK),
   .BYPASS_SRC   (BYPASS_SRC)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .in_irq (in_irq),
   .addr   (addr),
   .rd     (rd),
   .rdata  (rdata),
   .out_irq(out_irq)
);

// File: tb/sim_irq_xbar.sv
`timescale 1ns/1ps
module sim_irq_xbar;
   localparam int N_SRC = 12;
   localparam int N_OUT = 8;
   localparam int RB    = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_SRC-1:0]  in_irq = '0;
   logic [7:0]        addr = '0;
   logic [15:0]       wdata = '0;
   logic [1:0]        be = '0;
   logic              wr = 1'b0;
   logic              rd = 1'b0;
   logic [15:0]       rdata;
   logic [N_OUT-1:0]  out_irq;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   irq_xbar #(
      .N_SRC        (N_SRC),
      .N_OUT        (N_OUT),
      .REG_BYTES    (RB),
      .ADDR_W       (8),
      .SAFE_SEL     (9),
      .RESERVED_MASK(8'b0010_0100),
      .BYPASS_MASK  (8'b1000_1000),
      .BYPASS_SRC   ({8'd4, 8'd0, 8'd0, 8'd0, 8'd11, 8'd0, 8'd0, 8'd0})
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_irq(in_irq), .addr(addr), .wdata(wdata),
      .be(be), .wr(wr), .rd(rd), .rdata(rdata), .out_irq(out_irq)
   );

   // Slots: line0@0, line1@2, line3@4 (bypass 11), line4@6, line6@8, line7@10 (bypass 4)
   typedef struct packed {
      logic [7:0]  a;
      logic [15:0] d;
      logic [1:0]  b;
      logic [11:0] iv;
      logic [15:0] er;
      logic [7:0]  eo;
   } vec_t;

   localparam vec_t TBL [11] = '{
      '{8'd0,  16'h0003, 2'b11, 12'h008, 16'h0003, 8'h01},  // R1 R4 line0 -> src3
      '{8'd2,  16'h000B, 2'b11, 12'h800, 16'h000B, 8'h0A},  // R4 line1 -> src11
      '{8'd6,  16'h0005, 2'b01, 12'h210, 16'h0005, 8'hC0},  // R8 low byte only
      '{8'd8,  16'h0C00, 2'b10, 12'hFFF, 16'h0C09, 8'h9B},  // R2 R8 R5 high byte only
      '{8'd8,  16'h000C, 2'b11, 12'hFFF, 16'h000C, 8'h9B},  // R5 select == N_SRC
      '{8'd8,  16'h000B, 2'b11, 12'h800, 16'h000B, 8'h4A},  // R4 largest valid select
      '{8'd4,  16'h0000, 2'b11, 12'h800, 16'h000B, 8'h4A},  // R7 write to bypass slot
      '{8'd10, 16'h0001, 2'b11, 12'h012, 16'h0004, 8'h80},  // R7 second bypass slot
      '{8'd12, 16'h0001, 2'b11, 12'h008, 16'h0000, 8'h01},  // R9 beyond span
      '{8'd1,  16'h0000, 2'b11, 12'h008, 16'h0000, 8'h01},  // R1 R9 misaligned
      '{8'd2,  16'h0000, 2'b00, 12'h800, 16'h000B, 8'h4A}   // R8 no byte enabled
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(logic [7:0] a, logic [15:0] d, logic [1:0] b);
      @(negedge clk);
      addr = a; wdata = d; be = b; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; be = '0;
   endtask

   task automatic do_read(logic [7:0] a, output logic [15:0] v);
      addr = a; rd = 1'b1;
      #1;
      v = rdata;
      rd = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset loads safe source 9 into programmable lines
      do_read(8'd0, v);  chk("R3 line0 reset", 32'(v), 32'h9);
      do_read(8'd2, v);  chk("R3 line1 reset", 32'(v), 32'h9);
      do_read(8'd6, v);  chk("R3 line4 reset", 32'(v), 32'h9);
      do_read(8'd8, v);  chk("R3 line6 reset", 32'(v), 32'h9);
      in_irq = 12'h200; #1;
      chk("R3 R6 routing after reset", 32'(out_irq), 32'h53);
      do_read(8'd4, v);  chk("R7 bypass readback line3", 32'(v), 32'd11);
      do_read(8'd10, v); chk("R7 bypass readback line7", 32'(v), 32'd4);
      addr = 8'd0; #1;
      chk("R9 rd low gives zero", 32'(rdata), 32'h0);

      for (int k = 0; k < 11; k++) begin
         do_write(TBL[k].a, TBL[k].d, TBL[k].b);
         in_irq = TBL[k].iv;
         do_read(TBL[k].a, v);
         chk($sformatf("R1 R9 vector %0d readback", k), 32'(v), 32'(TBL[k].er));
         #1;
         chk($sformatf("R4 R5 R6 R7 vector %0d routing", k), 32'(out_irq), 32'(TBL[k].eo));
      end

      // R4: write becomes visible at the edge, not before
      in_irq = 12'h001;
      @(negedge clk);
      addr = 8'd0; wdata = 16'h0000; be = 2'b11; wr = 1'b1;
      #1;
      chk("R4 before write edge", 32'(out_irq[0]), 32'h0);
      @(posedge clk); #1;
      wr = 1'b0; be = '0;
      chk("R4 after write edge", 32'(out_irq[0]), 32'h1);

      // R3: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(8'd0, v); chk("R3 line0 after second reset", 32'(v), 32'h9);
      do_read(8'd8, v); chk("R3 line6 after second reset", 32'(v), 32'h9);
      in_irq = 12'h200; #1;
      chk("R3 routing after second reset", 32'(out_irq), 32'h53);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule